// File: doc/BRIEF.md
# Banked Code Memory Address Mapper

This block sits between a 16-bit CPU address bus and a 17-bit flash address bus. It lets the CPU reach six 16 KB code banks through one 16 KB window. The low 32 KB of CPU space is a common area that every bank shares, and it passes straight through. CPU addresses 8000h to BFFFh form the bank window, which the block steers into the bank chosen by a small select register. Addresses from C000h upward are not flash. For those the block drops its flash-select and hands the address on unchanged to other decoders.

The select register lives at CPU address FFF3h. Writes to it are guarded. A bank code of 6 or 7 is refused and raises a one-cycle error pulse. A write made while the program counter sits inside the bank window is also refused and sets a violation flag that stays set until reset. The block also checks two-byte accesses that run from 7FFFh into 8000h, which are legal only while bank 0 is selected. A separate combinational path translates a 20-bit logical bank address of the form bank×10000h + window offset into its physical flash address.

Top module: `bank_addr_map`

## Requirements
- R1: After reset the select register holds 0. rd_data at address FFF3h reads 00h, and code_err, win_viol and cross_fault are all 0.
- R2: Reading at address FFF3h returns the bank number in bits 2..0, with bits 7..3 always 0 whatever was written to them. Reading any other address returns 00h.
- R3: A CPU address in 0000h..7FFFh maps to the same physical address, zero-extended to 17 bits, with flash_sel=1, whatever bank is selected.
- R4: A CPU address in 8000h..BFFFh maps to physical 08000h + bank×4000h + address[13:0], with flash_sel=1. Bank 5 therefore reaches 1C000h..1FFFFh.
- R5: A CPU address at C000h or above drives flash_sel=0, and the physical address equals the CPU address zero-extended.
- R6: A register write whose bits 2..0 hold 6 or 7 leaves the register unchanged. code_err is then high for exactly the one cycle after the write edge.
- R7: A register write issued while pc lies in 8000h..BFFFh leaves the register unchanged and sets win_viol. win_viol stays set, even across later legal writes, until reset.
- R8: cross_fault is 1 when acc_wide=1, acc_addr=7FFFh and the selected bank is not 0. Otherwise it is 0.
- R9: For a logical address with bits 19..16 = n < 6 and bits 15..0 in 8000h..BFFFh, log_phys = 08000h + n×4000h + bits[13:0] and log_ok=1. Any other logical address gives log_ok=0 and log_phys=0.
- R10: A write with reg_wr_addr other than FFF3h does not change the select register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 16 | CPU address of the write |
| reg_wr_data | input | 8 | Write data; bits 2..0 carry the bank code |
| pc | input | 16 | Program counter of the writing instruction |
| reg_rd_addr | input | 16 | CPU address for register read |
| reg_rd_data | output | 8 | Read data |
| acc_addr | input | 16 | CPU fetch/access address |
| acc_wide | input | 1 | Access is two bytes wide (addr and addr+1) |
| phys_addr | output | 17 | Physical flash address |
| flash_sel | output | 1 | Access targets flash |
| cross_fault | output | 1 | Two-byte access crosses into the window with a nonzero bank |
| log_addr | input | 20 | Logical bank address to translate |
| log_phys | output | 17 | Translated physical address |
| log_ok | output | 1 | Logical address is a valid bank-window address |
| code_err | output | 1 | One-cycle pulse on a refused bank code |
| win_viol | output | 1 | Sticky flag: write attempted from inside the window |

## Verification
The bench builds the block with its default parameters: a 16-bit CPU bus, 14-bit window offset, 15-bit common area, a 3-bit bank field and six banks. With these values both ends of the window can be reached in bank 0 and in the top bank 5, along with both prohibited codes 6 and 7, and the crossing point 7FFFh with bank 0 and with a nonzero bank. The logical path is driven at its first and last valid pages, at page 6, and just outside both edges of the window.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
  // Outcome of a cycle at the select-register write port
  typedef enum logic [1:0] {
    WR_IDLE    = 2'd0,
    WR_TAKE    = 2'd1,
    WR_BADCODE = 2'd2,
    WR_INWIN   = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/bank_rst_sync.sv
module bank_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/bank_sel_reg.sv
module bank_sel_reg
  import bank_map_pkg::*;
#(
  parameter int unsigned CPU_AW    = 16,
  parameter int unsigned BANK_W    = 3,
  parameter int unsigned NUM_BANKS = 6,
  parameter logic [CPU_AW-1:0] REG_ADDR = 16'hFFF3,
  parameter logic [CPU_AW-1:0] WIN_LO   = 16'h8000,
  parameter logic [CPU_AW-1:0] WIN_HI   = 16'hBFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CPU_AW-1:0] wr_addr,
  input  logic [BANK_W-1:0] wr_code,
  input  logic [CPU_AW-1:0] pc,
  output logic [BANK_W-1:0] bank_o,
  output logic              code_err_o,
  output logic              viol_o
);
  localparam logic [BANK_W-1:0] LAST_CODE = BANK_W'(NUM_BANKS - 1);

  logic [BANK_W-1:0] bank_q, bank_d;
  logic              err_q, err_d;
  logic              viol_q, viol_d;
  logic              wr_hit, pc_in_win, code_ok;
  wr_kind_e          wr_kind;

  assign wr_hit    = wr_en && (wr_addr == REG_ADDR);
  assign pc_in_win = (pc >= WIN_LO) && (pc <= WIN_HI);
  assign code_ok   = (wr_code <= LAST_CODE);

  always_comb begin
    if (!wr_hit)        wr_kind = WR_IDLE;
    else if (pc_in_win) wr_kind = WR_INWIN;
    else if (!code_ok)  wr_kind = WR_BADCODE;
    else                wr_kind = WR_TAKE;
  end

  always_comb begin
    bank_d = bank_q;
    err_d  = 1'b0;
    viol_d = viol_q;
    unique case (wr_kind)
      WR_TAKE:    bank_d = wr_code;
      WR_BADCODE: err_d  = 1'b1;
      WR_INWIN:   viol_d = 1'b1;
      default:    ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      err_q  <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      bank_q <= bank_d;
      err_q  <= err_d;
      viol_q <= viol_d;
    end
  end

  assign bank_o     = bank_q;
  assign code_err_o = err_q;
  assign viol_o     = viol_q;

  // R4
  bank_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_q <= LAST_CODE);
  // R6
  bad_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !pc_in_win && !code_ok) |=> ($stable(bank_q) && err_q));
  // R7
  win_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && pc_in_win) |=> ($stable(bank_q) && viol_q));
  // R7
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q |=> viol_q);
  // R10
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(bank_q));
endmodule

// File: rtl/cpu_addr_xlate.sv
module cpu_addr_xlate #(
  parameter int unsigned CPU_AW  = 16,
  parameter int unsigned PHYS_AW = 17,
  parameter int unsigned BANK_W  = 3,
  parameter int unsigned WIN_AW  = 14,
  parameter logic [CPU_AW-1:0] WIN_LO = 16'h8000,
  parameter logic [CPU_AW-1:0] WIN_HI = 16'hBFFF
) (
  input  logic [BANK_W-1:0]  bank,
  input  logic [CPU_AW-1:0]  addr,
  input  logic               wide,
  output logic [PHYS_AW-1:0] phys,
  output logic               flash_sel,
  output logic               cross_fault
);
  localparam logic [CPU_AW-1:0] COMMON_LAST = WIN_LO - 1'b1;

  logic in_common, in_win;
  logic [PHYS_AW-1:0] win_phys;

  assign in_common = (addr < WIN_LO);
  assign in_win    = (addr >= WIN_LO) && (addr <= WIN_HI);
  assign win_phys  = PHYS_AW'(WIN_LO)
                   + PHYS_AW'({bank, {WIN_AW{1'b0}}})
                   + PHYS_AW'(addr[WIN_AW-1:0]);

  always_comb begin
    if (in_win) begin
      phys      = win_phys;
      flash_sel = 1'b1;
    end else begin
      phys      = PHYS_AW'(addr);
      flash_sel = in_common;
    end
  end

  assign cross_fault = wide && (addr == COMMON_LAST) && (bank != '0);
endmodule

// File: rtl/log_addr_xlate.sv
module log_addr_xlate #(
  parameter int unsigned CPU_AW    = 16,
  parameter int unsigned LOG_AW    = 20,
  parameter int unsigned PHYS_AW   = 17,
  parameter int unsigned BANK_W    = 3,
  parameter int unsigned WIN_AW    = 14,
  parameter int unsigned NUM_BANKS = 6,
  parameter logic [CPU_AW-1:0] WIN_LO = 16'h8000,
  parameter logic [CPU_AW-1:0] WIN_HI = 16'hBFFF
) (
  input  logic [LOG_AW-1:0]  log_addr,
  output logic [PHYS_AW-1:0] phys,
  output logic               ok
);
  localparam int unsigned PAGE_W = LOG_AW - CPU_AW;

  logic [PAGE_W-1:0] page;
  logic [CPU_AW-1:0] off;
  logic              page_ok, off_ok;

  assign page    = log_addr[LOG_AW-1:CPU_AW];
  assign off     = log_addr[CPU_AW-1:0];
  assign page_ok = (page < PAGE_W'(NUM_BANKS));
  assign off_ok  = (off >= WIN_LO) && (off <= WIN_HI);
  assign ok      = page_ok && off_ok;

  always_comb begin
    if (ok)
      phys = PHYS_AW'(WIN_LO)
           + PHYS_AW'({page[BANK_W-1:0], {WIN_AW{1'b0}}})
           + PHYS_AW'(off[WIN_AW-1:0]);
    else
      phys = '0;
  end
endmodule

// File: rtl/bank_addr_map.sv
module bank_addr_map #(
  parameter int unsigned CPU_AW    = 16,
  parameter int unsigned PHYS_AW   = 17,
  parameter int unsigned LOG_AW    = 20,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned BANK_W    = 3,
  parameter int unsigned NUM_BANKS = 6,
  parameter int unsigned COMMON_AW = 15,
  parameter int unsigned WIN_AW    = 14,
  parameter logic [CPU_AW-1:0] REG_ADDR = 16'hFFF3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic [CPU_AW-1:0]  reg_wr_addr,
  input  logic [DATA_W-1:0]  reg_wr_data,
  input  logic [CPU_AW-1:0]  pc,
  input  logic [CPU_AW-1:0]  reg_rd_addr,
  output logic [DATA_W-1:0]  reg_rd_data,
  input  logic [CPU_AW-1:0]  acc_addr,
  input  logic               acc_wide,
  output logic [PHYS_AW-1:0] phys_addr,
  output logic               flash_sel,
  output logic               cross_fault,
  input  logic [LOG_AW-1:0]  log_addr,
  output logic [PHYS_AW-1:0] log_phys,
  output logic               log_ok,
  output logic               code_err,
  output logic               win_viol
);
  localparam logic [CPU_AW-1:0] WIN_LO = CPU_AW'(1) << COMMON_AW;
  localparam logic [CPU_AW-1:0] WIN_HI = WIN_LO + ((CPU_AW'(1) << WIN_AW) - 1'b1);

  logic              rst_int_n;
  logic [BANK_W-1:0] bank;

  bank_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  bank_sel_reg #(
    .CPU_AW(CPU_AW), .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS),
    .REG_ADDR(REG_ADDR), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
  ) u_reg (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_en      (reg_wr_en),
    .wr_addr    (reg_wr_addr),
    .wr_code    (reg_wr_data[BANK_W-1:0]),
    .pc         (pc),
    .bank_o     (bank),
    .code_err_o (code_err),
    .viol_o     (win_viol)
  );

  cpu_addr_xlate #(
    .CPU_AW(CPU_AW), .PHYS_AW(PHYS_AW), .BANK_W(BANK_W), .WIN_AW(WIN_AW),
    .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
  ) u_cpu (
    .bank        (bank),
    .addr        (acc_addr),
    .wide        (acc_wide),
    .phys        (phys_addr),
    .flash_sel   (flash_sel),
    .cross_fault (cross_fault)
  );

  log_addr_xlate #(
    .CPU_AW(CPU_AW), .LOG_AW(LOG_AW), .PHYS_AW(PHYS_AW), .BANK_W(BANK_W),
    .WIN_AW(WIN_AW), .NUM_BANKS(NUM_BANKS), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
  ) u_log (
    .log_addr (log_addr),
    .phys     (log_phys),
    .ok       (log_ok)
  );

  assign reg_rd_data = (reg_rd_addr == REG_ADDR) ? DATA_W'(bank) : '0;

  // R3
  common_pass_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_addr < WIN_LO) |-> (flash_sel && phys_addr == PHYS_AW'(acc_addr)));
  // R5
  upper_pass_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_addr > WIN_HI) |-> (!flash_sel && phys_addr == PHYS_AW'(acc_addr)));
  // R8
  bank0_cross_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_rd_addr == REG_ADDR && reg_rd_data == '0) |-> !cross_fault);
  // R6
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (code_err && !reg_wr_en) |=> !code_err);
endmodule

// File: tb/tb_bank_addr_map.sv
module tb_bank_addr_map;
  typedef struct {
    int          sel;
    logic [19:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [15:0] reg_wr_addr, pc, reg_rd_addr, acc_addr;
  logic [7:0]  reg_wr_data, reg_rd_data;
  logic        acc_wide, flash_sel, cross_fault, log_ok, code_err, win_viol;
  logic [16:0] phys_addr, log_phys;
  logic [19:0] log_addr;

  item_t q[$];
  int checks = 0, errors = 0, cycles = 0;
  int m_bank = 0;
  bit m_viol = 0;

  always #2.5 clk = ~clk;

  bank_addr_map dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .pc(pc), .reg_rd_addr(reg_rd_addr),
    .reg_rd_data(reg_rd_data), .acc_addr(acc_addr), .acc_wide(acc_wide),
    .phys_addr(phys_addr), .flash_sel(flash_sel), .cross_fault(cross_fault),
    .log_addr(log_addr), .log_phys(log_phys), .log_ok(log_ok),
    .code_err(code_err), .win_viol(win_viol)
  );

  function automatic logic [19:0] win_map(int b, logic [15:0] a);
    return 20'h08000 + 20'(b) * 20'h04000 + 20'(a[13:0]);
  endfunction

  function automatic logic [19:0] pick(int sel);
    case (sel)
      0: return 20'(reg_rd_data);
      1: return 20'(phys_addr);
      2: return 20'(flash_sel);
      3: return 20'(code_err);
      4: return 20'(win_viol);
      5: return 20'(cross_fault);
      6: return 20'(log_phys);
      default: return 20'(log_ok);
    endcase
  endfunction

  task automatic expect_v(int sel, logic [19:0] e, string r);
    item_t it;
    it.sel = sel; it.exp = e; it.req = r;
    q.push_back(it);
  endtask

  // Monitor: compare all expectations queued this cycle
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (pick(it.sel) !== it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, pick(it.sel), it.exp);
      end
    end
  end

  task automatic flags(string r);
    expect_v(0, 20'(m_bank), r);
    expect_v(4, 20'(m_viol), r);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; reg_wr_en = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    m_bank = 0; m_viol = 0;
    #1;
    reg_rd_addr = 16'hFFF3; acc_addr = 16'h0000; acc_wide = 1'b0;
    // R1: reset state
    expect_v(0, 20'h0, "R1"); expect_v(3, 20'h0, "R1");
    expect_v(4, 20'h0, "R1"); expect_v(5, 20'h0, "R1");
  endtask

  task automatic access(logic [15:0] a, logic w, string r);
    logic [19:0] e;
    logic        fs;
    @(posedge clk); #1;
    acc_addr = a; acc_wide = w;
    if (a < 16'h8000)      begin e = 20'(a); fs = 1'b1; end
    else if (a < 16'hC000) begin e = win_map(m_bank, a); fs = 1'b1; end
    else                   begin e = 20'(a); fs = 1'b0; end
    expect_v(1, e, r);
    expect_v(2, 20'(fs), r);
    expect_v(5, 20'(w && a == 16'h7FFF && m_bank != 0), "R8");
  endtask

  task automatic write(logic [15:0] wa, logic [7:0] d, logic [15:0] p, string r);
    bit bad;
    @(posedge clk); #1;
    reg_wr_en = 1'b1; reg_wr_addr = wa; reg_wr_data = d; pc = p;
    @(posedge clk); #1;
    reg_wr_en = 1'b0; reg_rd_addr = 16'hFFF3;
    bad = 1'b0;
    if (wa == 16'hFFF3) begin
      if (p >= 16'h8000 && p <= 16'hBFFF) m_viol = 1'b1;
      else if (int'(d[2:0]) > 5)          bad = 1'b1;
      else                                m_bank = int'(d[2:0]);
    end
    flags(r);
    expect_v(3, 20'(bad), r);
    if (bad) begin
      @(posedge clk); #1;
      // R6: pulse lasts one cycle only
      expect_v(3, 20'h0, "R6");
    end
  endtask

  task automatic logical(logic [19:0] la, logic [19:0] e, logic k);
    @(posedge clk); #1;
    log_addr = la;
    expect_v(6, e, "R9");
    expect_v(7, 20'(k), "R9");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_wr_addr = '0; reg_wr_data = '0;
    pc = '0; reg_rd_addr = 16'hFFF3; acc_addr = '0; acc_wide = 1'b0;
    log_addr = '0;
    do_reset();
    // R3 common area
    access(16'h1234, 1'b0, "R3");
    access(16'h7FFF, 1'b0, "R3");
    // R4 bank 0 window edges
    access(16'h8000, 1'b0, "R4");
    access(16'hBFFF, 1'b0, "R4");
    // R2: upper data bits set, code 3
    write(16'hFFF3, 8'hFB, 16'h0100, "R2");
    access(16'h8123, 1'b0, "R4");
    access(16'h0042, 1'b0, "R3");
    // R8 crossing with nonzero bank
    access(16'h7FFF, 1'b1, "R8");
    access(16'h7FFE, 1'b1, "R8");
    // R5 non-flash region
    access(16'hC000, 1'b0, "R5");
    access(16'hFFF3, 1'b0, "R5");
    // R6 prohibited codes
    write(16'hFFF3, 8'h06, 16'h0200, "R6");
    write(16'hFFF3, 8'h07, 16'h0200, "R6");
    access(16'h9000, 1'b0, "R6");
    // R10 write elsewhere ignored; R2 read elsewhere is zero
    write(16'hFFF2, 8'h01, 16'h0200, "R10");
    @(posedge clk); #1;
    reg_rd_addr = 16'hFFF2;
    expect_v(0, 20'h0, "R2");
    // top bank
    write(16'hFFF3, 8'h05, 16'h0300, "R4");
    access(16'hBFFF, 1'b0, "R4");
    access(16'h8000, 1'b0, "R4");
    // R7 write from inside window
    write(16'hFFF3, 8'h01, 16'h8010, "R7");
    write(16'hFFF3, 8'h02, 16'hBFFF, "R7");
    write(16'hFFF3, 8'h00, 16'h7FFF, "R7");
    access(16'h7FFF, 1'b1, "R8");
    access(16'hA000, 1'b0, "R4");
    // R9 logical translation
    logical(20'h28123, 20'h10123, 1'b1);
    logical(20'h58000, 20'h1C000, 1'b1);
    logical(20'h5BFFF, 20'h1FFFF, 1'b1);
    logical(20'h08000, 20'h08000, 1'b1);
    logical(20'h68000, 20'h00000, 1'b0);
    logical(20'h27FFF, 20'h00000, 1'b0);
    logical(20'h2C000, 20'h00000, 1'b0);
    // R1 reset clears sticky flag and bank
    write(16'hFFF3, 8'h04, 16'h0010, "R4");
    do_reset();
    access(16'h8001, 1'b0, "R1");
    @(posedge clk); @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule